// File: doc/BRIEF.md
# Forwarding General-Purpose Register File

This block holds the general-purpose registers of a simple in-order pipelined processor. An instruction can name up to three source operands, so there are three read ports. Results come back through one write port, and at most one write happens per cycle.

Each read port is combinational: the data follows the port's address with no clock edge in between. A write is stored at the next rising clock edge. When a write and a read use the same register index in the same cycle, the read port returns the value being written instead of the stored value. This lets a stage that reads operands see a result produced in that same cycle without stalling. Each read port also has an enable that marks a genuine operand fetch. The enable only gates an optional simulation trace and never changes the read data.

Top module: `gpr_bypass_file`

## Requirements
- R1: While reset (rst_n low) is held and after it is released, every register reads as zero until it is written.
- R2: With wr_en high at a rising clock edge, wr_data is stored at index wr_addr. From the following cycle, any read port addressing that index returns it.
- R3: In a cycle where wr_en is high and a read port's address equals wr_addr, that port returns wr_data in the same cycle, before the clock edge.
- R4: Each read port compares its own address with wr_addr. Any subset of the three ports, including all three at once, can receive the forwarded value, while ports at other indices return stored contents.
- R5: With wr_en low, no port forwards wr_data, whatever wr_addr and wr_data hold, and no register changes at the clock edge.
- R6: Read data follows a change of read address within the same cycle, without a clock edge.
- R7: The per-port read enables have no effect on the read data.
- R8: A write changes only the register at wr_addr. All other registers keep their contents.
- R9: All indices from 0 through 31 are ordinary storage. Index 0 is not hard-wired to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears all registers |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | 5 | Register index written |
| wr_data | input | 64 | Value written |
| rd0_en | input | 1 | Port 0 carries a genuine operand read (tracing only) |
| rd0_addr | input | 5 | Port 0 register index |
| rd0_data | output | 64 | Port 0 read data |
| rd1_en | input | 1 | Port 1 carries a genuine operand read (tracing only) |
| rd1_addr | input | 5 | Port 1 register index |
| rd1_data | output | 64 | Port 1 read data |
| rd2_en | input | 1 | Port 2 carries a genuine operand read (tracing only) |
| rd2_addr | input | 5 | Port 2 register index |
| rd2_data | output | 64 | Port 2 read data |

## Verification
A forwarded value or an address change is due in the same cycle as the stimulus, because no register lies between the inputs and the read data. A stored value is due from the first cycle after the rising edge that commits it. The bench drives inputs just after the falling edge and samples 1 ns later, while the clock is still low. This separates the same-cycle bypass result from the committed result. The next rising edge then performs the write, and the following table row reads it back.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
    localparam int GPRF_READ_PORTS   = 3;
    localparam int GPRF_DEFAULT_REGS = 32;
    localparam int GPRF_DEFAULT_W    = 64;
    localparam int GPRF_MAX_AW       = 8;

    typedef logic [GPRF_MAX_AW-1:0] gprf_idx_t;

    // True when a live write targets the register a read port asks for.
    function automatic logic port_hit(input logic en, input gprf_idx_t wa, input gprf_idx_t ra);
        return en && (wa == ra);
    endfunction
endpackage

// File: rtl/gprf_storage.sv
module gprf_storage #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 64,
    parameter int NUM_RD   = 3,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr [NUM_RD],
    output logic [DATA_W-1:0] rd_stored [NUM_RD]
);
    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (wr_en) begin
            regs_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_stored[p] = regs_q[rd_addr[p]];
    end
endmodule

// File: rtl/gprf_bypass.sv
module gprf_bypass
    import gprf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 64,
    parameter int NUM_RD   = 3,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr [NUM_RD],
    input  logic [DATA_W-1:0] rd_stored [NUM_RD],
    output logic [DATA_W-1:0] rd_data [NUM_RD]
);
    logic hit_d [NUM_RD];

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        always_comb begin
            hit_d[p] = port_hit(wr_en, gprf_idx_t'(wr_addr), gprf_idx_t'(rd_addr[p]));
            rd_data[p] = hit_d[p] ? wr_data : rd_stored[p];
        end
    end
endmodule

// File: rtl/gprf_trace.sv
module gprf_trace #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 64,
    parameter int NUM_RD   = 3,
    parameter bit TRACE_EN = 1'b0,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rd_en   [NUM_RD],
    input  logic [ADDR_W-1:0] rd_addr [NUM_RD],
    input  logic [DATA_W-1:0] rd_data [NUM_RD]
);
    // Display only; drives nothing, so it vanishes from a netlist.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_trace
        always_ff @(posedge clk) begin
            if (TRACE_EN && rd_en[p]) begin
                $display("gpr read port %0d: r%0d = %h", p, rd_addr[p], rd_data[p]);
            end
        end
    end
endmodule

// File: rtl/gpr_bypass_file.sv
module gpr_bypass_file
    import gprf_pkg::*;
#(
    parameter int NUM_REGS = GPRF_DEFAULT_REGS,
    parameter int DATA_W   = GPRF_DEFAULT_W,
    parameter bit TRACE_EN = 1'b0,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd0_en,
    input  logic [ADDR_W-1:0] rd0_addr,
    output logic [DATA_W-1:0] rd0_data,
    input  logic              rd1_en,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              rd2_en,
    input  logic [ADDR_W-1:0] rd2_addr,
    output logic [DATA_W-1:0] rd2_data
);
    localparam int NRD = GPRF_READ_PORTS;

    logic              en_v     [NRD];
    logic [ADDR_W-1:0] addr_v   [NRD];
    logic [DATA_W-1:0] stored_v [NRD];
    logic [DATA_W-1:0] data_v   [NRD];

    assign en_v[0]   = rd0_en;
    assign en_v[1]   = rd1_en;
    assign en_v[2]   = rd2_en;
    assign addr_v[0] = rd0_addr;
    assign addr_v[1] = rd1_addr;
    assign addr_v[2] = rd2_addr;
    assign rd0_data  = data_v[0];
    assign rd1_data  = data_v[1];
    assign rd2_data  = data_v[2];

    gprf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NRD)) i_storage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (addr_v),
        .rd_stored (stored_v)
    );

    gprf_bypass #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NRD)) i_bypass (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (addr_v),
        .rd_stored (stored_v),
        .rd_data   (data_v)
    );

    gprf_trace #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NRD), .TRACE_EN(TRACE_EN)) i_trace (
        .clk     (clk),
        .rd_en   (en_v),
        .rd_addr (addr_v),
        .rd_data (data_v)
    );
endmodule

// File: rtl/gprf_checker.sv
module gprf_checker #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd0_addr,
    input logic [DATA_W-1:0] rd0_data,
    input logic [ADDR_W-1:0] rd1_addr,
    input logic [DATA_W-1:0] rd1_data,
    input logic [ADDR_W-1:0] rd2_addr,
    input logic [DATA_W-1:0] rd2_data
);
    AST_FWD_RD0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd0_addr == wr_addr) |-> rd0_data == wr_data); // R3
    AST_FWD_RD1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd1_addr == wr_addr) |-> rd1_data == wr_data); // R4
    AST_FWD_RD2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd2_addr == wr_addr) |-> rd2_data == wr_data); // R4
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && rd0_addr == $past(wr_addr)
         && !(wr_en && wr_addr == rd0_addr)) |-> rd0_data == $past(wr_data)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && !wr_en && $stable(rd1_addr)) |-> $stable(rd1_data)); // R5
endmodule

bind gpr_bypass_file gprf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_gprf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd0_addr (rd0_addr),
    .rd0_data (rd0_data),
    .rd1_addr (rd1_addr),
    .rd1_data (rd1_data),
    .rd2_addr (rd2_addr),
    .rd2_data (rd2_data)
);

// File: tb/test_gpr_bypass_file.sv
`timescale 1ns/1ps
module test_gpr_bypass_file;
    localparam int AW = 5;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd0_en = 1'b0, rd1_en = 1'b0, rd2_en = 1'b0;
    logic [AW-1:0] rd0_addr = '0, rd1_addr = '0, rd2_addr = '0;
    logic [DW-1:0] rd0_data, rd1_data, rd2_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    gpr_bypass_file i_gpr_bypass_file (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .rd2_en(rd2_en), .rd2_addr(rd2_addr), .rd2_data(rd2_data)
    );

    typedef struct packed {
        logic          we;
        logic [AW-1:0] wa;
        logic [DW-1:0] wd;
        logic [AW-1:0] a0, a1, a2;
        logic [2:0]    en;
        logic [DW-1:0] e0, e1, e2;
    } vec_t;

    localparam logic [DW-1:0] VA = 64'hA1A1_0000_0000_0005;
    localparam logic [DW-1:0] VB = 64'hB2B2_1111_2222_001F;
    localparam logic [DW-1:0] VC = 64'hC3C3_DEAD_BEEF_0000;
    localparam logic [DW-1:0] VD = 64'hD4D4_FFFF_0000_0505;
    localparam logic [DW-1:0] VE = 64'hE5E5_1234_5678_0007;
    localparam logic [DW-1:0] VX = 64'hFFFF_FFFF_FFFF_FFFF;

    // Each row: bypass result sampled before the edge, then the edge commits.
    localparam vec_t VECS [8] = '{
        '{1'b1, 5'd5,  VA,   5'd5,  5'd5,  5'd0,  3'b111, VA, VA, 64'd0},  // R3 R4
        '{1'b0, 5'd5,  VX,   5'd5,  5'd6,  5'd31, 3'b000, VA, 64'd0, 64'd0}, // R5 R2
        '{1'b1, 5'd31, VB,   5'd31, 5'd5,  5'd31, 3'b101, VB, VA, VB},       // R4
        '{1'b1, 5'd0,  VC,   5'd0,  5'd31, 5'd0,  3'b010, VC, VB, VC},       // R9
        '{1'b1, 5'd5,  VD,   5'd5,  5'd0,  5'd31, 3'b111, VD, VC, VB},       // R3
        '{1'b0, 5'd0,  64'd0,5'd5,  5'd0,  5'd31, 3'b011, VD, VC, VB},       // R8
        '{1'b1, 5'd7,  VE,   5'd6,  5'd8,  5'd9,  3'b100, 64'd0, 64'd0, 64'd0}, // R4
        '{1'b0, 5'd7,  VA,   5'd7,  5'd7,  5'd7,  3'b001, VE, VE, VE}        // R2
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_reads(input logic [AW-1:0] a0, input logic [AW-1:0] a1, input logic [AW-1:0] a2);
        rd0_addr = a0; rd1_addr = a1; rd2_addr = a2;
    endtask

    initial begin
        // R1: reads during reset
        repeat (3) @(negedge clk);
        set_reads(5'd0, 5'd17, 5'd31);
        #1;
        chk("R1 reset r0", rd0_data, '0);
        chk("R1 reset r17", rd1_data, '0);
        chk("R1 reset r31", rd2_data, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 after release r17", rd1_data, '0);

        // table walk
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            wr_en = VECS[i].we; wr_addr = VECS[i].wa; wr_data = VECS[i].wd;
            set_reads(VECS[i].a0, VECS[i].a1, VECS[i].a2);
            {rd0_en, rd1_en, rd2_en} = VECS[i].en;
            #1;
            chk($sformatf("R3/R4 row %0d port0", i), rd0_data, VECS[i].e0);
            chk($sformatf("R3/R4 row %0d port1", i), rd1_data, VECS[i].e1);
            chk($sformatf("R3/R4 row %0d port2", i), rd2_data, VECS[i].e2);
        end

        // R6: address change within one low phase, no edge in between
        @(negedge clk);
        wr_en = 1'b0;
        set_reads(5'd5, 5'd5, 5'd5);
        #0.5;
        chk("R6 addr r5", rd0_data, VD);
        set_reads(5'd0, 5'd5, 5'd5);
        #0.5;
        chk("R6 addr r0", rd0_data, VC);

        // R7: enables toggled, data unchanged
        {rd0_en, rd1_en, rd2_en} = 3'b000;
        #0.3;
        chk("R7 enables low", rd1_data, VD);
        {rd0_en, rd1_en, rd2_en} = 3'b111;
        #0.3;
        chk("R7 enables high", rd1_data, VD);

        // R5: disabled write with matching address leaves r5 intact
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 5'd5; wr_data = VX;
        set_reads(5'd5, 5'd5, 5'd5);
        @(negedge clk);
        #1;
        chk("R5 no store", rd2_data, VD);

        // R8: write r9, r5 and r0 intact
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd9; wr_data = VE;
        @(negedge clk);
        wr_en = 1'b0;
        set_reads(5'd9, 5'd5, 5'd0);
        #1;
        chk("R8 written r9", rd0_data, VE);
        chk("R8 kept r5", rd1_data, VD);
        chk("R8 kept r0", rd2_data, VC);

        // R1: reset mid-run clears stored values
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        set_reads(5'd9, 5'd5, 5'd31);
        #1;
        chk("R1 cleared r9", rd0_data, '0);
        chk("R1 cleared r5", rd1_data, '0);
        chk("R1 cleared r31", rd2_data, '0);

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule